// File: doc/BRIEF.md
# Trapdoor Configuration Register File

This block sits behind the eight-byte I/O window of a legacy disk task file and hides a small set of configuration registers inside it. While the window is locked, every host access passes straight through to the task-file port. A fixed access pattern opens the hidden space:

- two consecutive halfword reads of offset 1;
- then a byte write of 0x03 to offset 2.

From the next cycle on, byte writes land in the hidden registers instead of the task file. A byte write of 0x83 to offset 2 closes the window again.

The hidden space holds the following state:

- one read-cycle timing byte and one write-cycle timing byte for each attached device;
- a shared address-setup field;
- a control byte whose low bit lets the programmed timings override the built-in defaults;
- a strap byte loaded from pins at reset.

A locked probe sequence reports the bus clock-speed indication.

Top module: `tf_trapdoor_cfg`

## Requirements
- R1: While reset is held, on each clock the block returns to the locked, idle state. It clears the control and miscellaneous bytes, loads the strap byte from `strapPins`, and sets every read and write timing bank to 0x6B.
- R2: While locked, each bus strobe drives the matching task-file strobe in the same cycle. `tfAddr` and `tfWdata` carry the bus address and data, and `busRdata` returns `tfRdata` (except in the R9 case).
- R3: With the window locked, two consecutive halfword reads at offset 1 followed by a byte write of 0x03 to offset 2 open the window from the next cycle. The opening write itself is still forwarded to the task file.
- R4: Any other access made before the pattern completes returns the tracker to idle, so the whole pattern must start again. A byte read at offset 1 or a wrong key byte counts as such an access. A third or later halfword read at offset 1 keeps the tracker at "two seen". Idle cycles with no strobe leave the tracker unchanged.
- R5: While open, a byte write at offset 0 updates the read timing bank, and a byte write at offset 1 updates the write timing bank. In both cases the bank is the one of the device selected by bit 0 of the miscellaneous byte (0 = device 0, 1 = device 1).
- R6: While open, byte writes at offset 3, 5 and 6 load the control, strap and miscellaneous bytes. The shared address-setup output is bits 5:4 of the miscellaneous byte.
- R7: While open, no task-file strobe is asserted and `busRdata` is zero. A byte write of 0x83 to offset 2 locks the window from the next cycle, while any other byte at offset 2 leaves it open and changes nothing.
- R8: When control bit 0 is 1, each device's timing outputs show its programmed banks. When it is 0, every timing output shows 0x6B.
- R9: While locked, a byte write of 0xFF to offset 5 arms a probe. If the very next strobed access is a halfword read at offset 5, `busRdata` returns the `clkSpeed` input in bit 0 with all other bits zero, and the read is still forwarded. Any other access disarms the probe, and so does opening the window.
- R10: Accesses made while locked leave all hidden registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| busAddr | input | ADDR_W | Host window offset |
| busRd8 | input | 1 | Host byte read strobe |
| busRd16 | input | 1 | Host halfword read strobe |
| busWr8 | input | 1 | Host byte write strobe |
| busWr16 | input | 1 | Host halfword write strobe |
| busWdata | input | DATA_W | Host write data (byte writes use bits 7:0) |
| busRdata | output | DATA_W | Host read data |
| tfAddr | output | ADDR_W | Task-file offset |
| tfRd8 | output | 1 | Task-file byte read strobe |
| tfRd16 | output | 1 | Task-file halfword read strobe |
| tfWr8 | output | 1 | Task-file byte write strobe |
| tfWr16 | output | 1 | Task-file halfword write strobe |
| tfWdata | output | DATA_W | Task-file write data |
| tfRdata | input | DATA_W | Task-file read data |
| strapPins | input | 8 | Strap value loaded during reset |
| clkSpeed | input | 1 | Bus clock-speed indication |
| cfgOpen | output | 1 | Hidden window is open |
| rdTiming | output | NDEV x 8 | Effective read-cycle timing per device |
| wrTiming | output | NDEV x 8 | Effective write-cycle timing per device |
| addrSetup | output | 2 | Shared address-setup field |
| ctrlReg | output | 8 | Control byte |
| strapReg | output | 8 | Strap byte |
| miscReg | output | 8 | Miscellaneous byte |
| overrideOn | output | 1 | Programmed timings in force |

## Verification
Three functions can land on the same access.

- The write that completes the unlock pattern is forwarded to the task file in the same cycle that it flips the window, and the bench places a hidden-register write on the very next cycle to confirm the switch.
- The probe-arming write at offset 5 also breaks a partial unlock pattern. The bench arms the probe in the middle of a pattern and then checks two things: the probe read returns `clkSpeed`, and a later opening key is refused.
- The relock write shares its cycle with the end of hidden decoding. The bench issues a task-file access right after relocking and checks that it is forwarded.

A behavioural model predicts each port on every clock, over directed runs and a randomized run biased toward the key bytes.

// File: rtl/tdcfg_pkg.sv
package tdcfg_pkg;

  // Window offsets whose meaning the decode depends on
  localparam logic [2:0] OFS_RDTIM = 3'd0;
  localparam logic [2:0] OFS_WRTIM = 3'd1;
  localparam logic [2:0] OFS_ERR   = 3'd1;
  localparam logic [2:0] OFS_GATE  = 3'd2;
  localparam logic [2:0] OFS_CTRL  = 3'd3;
  localparam logic [2:0] OFS_STRAP = 3'd5;
  localparam logic [2:0] OFS_MISC  = 3'd6;

  localparam logic [7:0] KEY_OPEN  = 8'h03;
  localparam logic [7:0] KEY_CLOSE = 8'h83;
  localparam logic [7:0] PROBE_KEY = 8'hFF;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ONE  = 2'd1,
    SEQ_TWO  = 2'd2,
    SEQ_OPEN = 2'd3
  } seqState_e;

  // Strobes from the sequencer to the register datapath
  typedef struct packed {
    logic locked;
    logic probeHit;
    logic wrRdTim;
    logic wrWrTim;
    logic wrCtrl;
    logic wrStrap;
    logic wrMisc;
  } cfgStrobe_t;

endpackage

// File: rtl/tdcfg_seq.sv
module tdcfg_seq
  import tdcfg_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busRd8,
  input  logic              busRd16,
  input  logic              busWr8,
  input  logic              busWr16,
  input  logic [7:0]        wrByte,
  output cfgStrobe_t        stb
);

  seqState_e stateQ, stateD;
  logic      probeQ, probeD;

  logic anyAcc, errRd, keyOpen, keyClose, probeArm, probeRd, isOpen;

  assign anyAcc   = busRd8 | busRd16 | busWr8 | busWr16;
  assign errRd    = busRd16 && (busAddr == ADDR_W'(OFS_ERR));
  assign keyOpen  = busWr8 && (busAddr == ADDR_W'(OFS_GATE)) && (wrByte == KEY_OPEN);
  assign keyClose = busWr8 && (busAddr == ADDR_W'(OFS_GATE)) && (wrByte == KEY_CLOSE);
  assign probeArm = busWr8 && (busAddr == ADDR_W'(OFS_STRAP)) && (wrByte == PROBE_KEY);
  assign probeRd  = busRd16 && (busAddr == ADDR_W'(OFS_STRAP));
  assign isOpen   = (stateQ == SEQ_OPEN);

  always_comb begin
    stateD = stateQ;
    probeD = probeQ;
    if (isOpen) begin
      probeD = 1'b0;
      if (keyClose) stateD = SEQ_IDLE;
    end else if (anyAcc) begin
      probeD = probeArm;
      if (errRd)
        stateD = (stateQ == SEQ_IDLE) ? SEQ_ONE : SEQ_TWO;
      else if (keyOpen && stateQ == SEQ_TWO)
        stateD = SEQ_OPEN;
      else
        stateD = SEQ_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= SEQ_IDLE;
      probeQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      probeQ <= probeD;
    end
  end

  always_comb begin
    stb          = '0;
    stb.locked   = !isOpen;
    stb.probeHit = !isOpen && probeQ && probeRd;
    stb.wrRdTim  = isOpen && busWr8 && (busAddr == ADDR_W'(OFS_RDTIM));
    stb.wrWrTim  = isOpen && busWr8 && (busAddr == ADDR_W'(OFS_WRTIM));
    stb.wrCtrl   = isOpen && busWr8 && (busAddr == ADDR_W'(OFS_CTRL));
    stb.wrStrap  = isOpen && busWr8 && (busAddr == ADDR_W'(OFS_STRAP));
    stb.wrMisc   = isOpen && busWr8 && (busAddr == ADDR_W'(OFS_MISC));
  end

  // R3
  unlock_opens_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == SEQ_TWO && keyOpen) |=> !stb.locked);

  // R4
  no_early_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.locked && stateQ != SEQ_TWO) |=> stb.locked);

  // R7
  relock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.locked && keyClose) |=> stb.locked);

  // R7
  stay_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.locked && !keyClose) |=> !stb.locked);

endmodule

// File: rtl/tdcfg_regs.sv
module tdcfg_regs
  import tdcfg_pkg::*;
#(
  parameter int         NDEV    = 2,
  parameter logic [7:0] DEF_TIM = 8'h6B
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  cfgStrobe_t           stb,
  input  logic [7:0]           wrByte,
  input  logic [7:0]           strapPins,
  output logic [NDEV-1:0][7:0] rdTimEff,
  output logic [NDEV-1:0][7:0] wrTimEff,
  output logic [1:0]           addrSetup,
  output logic [7:0]           ctrlQ,
  output logic [7:0]           strapQ,
  output logic [7:0]           miscQ,
  output logic                 overrideOn
);

  localparam int SEL_W = (NDEV > 1) ? $clog2(NDEV) : 1;

  logic [NDEV-1:0][7:0] rdBank, wrBank;
  logic [SEL_W-1:0]     devSel;

  assign devSel     = miscQ[SEL_W-1:0];
  assign overrideOn = ctrlQ[0];
  assign addrSetup  = miscQ[5:4];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ  <= 8'h00;
      strapQ <= strapPins;
      miscQ  <= 8'h00;
    end else begin
      if (stb.wrCtrl)  ctrlQ  <= wrByte;
      if (stb.wrStrap) strapQ <= wrByte;
      if (stb.wrMisc)  miscQ  <= wrByte;
    end
  end

  for (genvar g = 0; g < NDEV; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (!rstN) begin
        rdBank[g] <= DEF_TIM;
        wrBank[g] <= DEF_TIM;
      end else begin
        if (stb.wrRdTim && devSel == SEL_W'(g)) rdBank[g] <= wrByte;
        if (stb.wrWrTim && devSel == SEL_W'(g)) wrBank[g] <= wrByte;
      end
    end
    assign rdTimEff[g] = overrideOn ? rdBank[g] : DEF_TIM;
    assign wrTimEff[g] = overrideOn ? wrBank[g] : DEF_TIM;
  end

  // R10
  locked_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.locked |=> ($stable(ctrlQ) && $stable(strapQ) && $stable(miscQ)
                    && $stable(rdBank) && $stable(wrBank)));

  // R5
  bank0_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrRdTim && devSel == '0) |=> (rdBank[0] == $past(wrByte)));

endmodule

// File: rtl/tf_trapdoor_cfg.sv
module tf_trapdoor_cfg
  import tdcfg_pkg::*;
#(
  parameter int         ADDR_W  = 3,
  parameter int         DATA_W  = 16,
  parameter int         NDEV    = 2,
  parameter logic [7:0] DEF_TIM = 8'h6B
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busRd8,
  input  logic                 busRd16,
  input  logic                 busWr8,
  input  logic                 busWr16,
  input  logic [DATA_W-1:0]    busWdata,
  output logic [DATA_W-1:0]    busRdata,
  output logic [ADDR_W-1:0]    tfAddr,
  output logic                 tfRd8,
  output logic                 tfRd16,
  output logic                 tfWr8,
  output logic                 tfWr16,
  output logic [DATA_W-1:0]    tfWdata,
  input  logic [DATA_W-1:0]    tfRdata,
  input  logic [7:0]           strapPins,
  input  logic                 clkSpeed,
  output logic                 cfgOpen,
  output logic [NDEV-1:0][7:0] rdTiming,
  output logic [NDEV-1:0][7:0] wrTiming,
  output logic [1:0]           addrSetup,
  output logic [7:0]           ctrlReg,
  output logic [7:0]           strapReg,
  output logic [7:0]           miscReg,
  output logic                 overrideOn
);

  cfgStrobe_t stb;

  tdcfg_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk     (clk),
    .rstN    (rstN),
    .busAddr (busAddr),
    .busRd8  (busRd8),
    .busRd16 (busRd16),
    .busWr8  (busWr8),
    .busWr16 (busWr16),
    .wrByte  (busWdata[7:0]),
    .stb     (stb)
  );

  tdcfg_regs #(.NDEV(NDEV), .DEF_TIM(DEF_TIM)) u_regs (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrByte     (busWdata[7:0]),
    .strapPins  (strapPins),
    .rdTimEff   (rdTiming),
    .wrTimEff   (wrTiming),
    .addrSetup  (addrSetup),
    .ctrlQ      (ctrlReg),
    .strapQ     (strapReg),
    .miscQ      (miscReg),
    .overrideOn (overrideOn)
  );

  assign cfgOpen = !stb.locked;
  assign tfAddr  = busAddr;
  assign tfWdata = busWdata;
  assign tfRd8   = stb.locked & busRd8;
  assign tfRd16  = stb.locked & busRd16;
  assign tfWr8   = stb.locked & busWr8;
  assign tfWr16  = stb.locked & busWr16;

  always_comb begin
    if (!stb.locked)      busRdata = '0;
    else if (stb.probeHit) busRdata = {{(DATA_W-1){1'b0}}, clkSpeed};
    else                  busRdata = tfRdata;
  end

endmodule

// File: tb/tf_trapdoor_cfg_bench.sv
module tf_trapdoor_cfg_bench;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic            rstN = 1'b0;
  logic [2:0]      busAddr = '0;
  logic            busRd8 = 0, busRd16 = 0, busWr8 = 0, busWr16 = 0;
  logic [15:0]     busWdata = '0;
  logic [15:0]     busRdata;
  logic [2:0]      tfAddr;
  logic            tfRd8, tfRd16, tfWr8, tfWr16;
  logic [15:0]     tfWdata;
  logic [15:0]     tfRdata = '0;
  logic [7:0]      strapPins = 8'h5A;
  logic            clkSpeed = 1'b0;
  logic            cfgOpen;
  logic [1:0][7:0] rdTiming, wrTiming;
  logic [1:0]      addrSetup;
  logic [7:0]      ctrlReg, strapReg, miscReg;
  logic            overrideOn;

  tf_trapdoor_cfg u_tf_trapdoor_cfg (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busRd8(busRd8), .busRd16(busRd16),
    .busWr8(busWr8), .busWr16(busWr16), .busWdata(busWdata), .busRdata(busRdata),
    .tfAddr(tfAddr), .tfRd8(tfRd8), .tfRd16(tfRd16), .tfWr8(tfWr8), .tfWr16(tfWr16),
    .tfWdata(tfWdata), .tfRdata(tfRdata), .strapPins(strapPins), .clkSpeed(clkSpeed),
    .cfgOpen(cfgOpen), .rdTiming(rdTiming), .wrTiming(wrTiming), .addrSetup(addrSetup),
    .ctrlReg(ctrlReg), .strapReg(strapReg), .miscReg(miscReg), .overrideOn(overrideOn)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Behavioural model: 0 idle, 1 one read, 2 two reads, 3 open
  int         mState;
  bit         mProbe;
  logic [7:0] mRd [2];
  logic [7:0] mWr [2];
  logic [7:0] mCtrl, mStrap, mMisc;

  localparam int K_IDLE = 0, K_RD8 = 1, K_RD16 = 2, K_WR8 = 3, K_WR16 = 4;

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic checkRegs(string tag);
    chk(tag, "cfgOpen", 16'(cfgOpen), 16'(mState == 3));
    for (int i = 0; i < 2; i++) begin
      chk(tag, "rdTiming", 16'(rdTiming[i]), 16'(mCtrl[0] ? mRd[i] : 8'h6B));
      chk(tag, "wrTiming", 16'(wrTiming[i]), 16'(mCtrl[0] ? mWr[i] : 8'h6B));
    end
    chk(tag, "addrSetup", 16'(addrSetup), 16'(mMisc[5:4]));
    chk(tag, "ctrlReg", 16'(ctrlReg), 16'(mCtrl));
    chk(tag, "strapReg", 16'(strapReg), 16'(mStrap));
    chk(tag, "miscReg", 16'(miscReg), 16'(mMisc));
    chk(tag, "overrideOn", 16'(overrideOn), 16'(mCtrl[0]));
  endtask

  task automatic modelUpdate(int kind, logic [2:0] a, logic [7:0] d);
    if (mState == 3) begin
      mProbe = 0;
      if (kind == K_WR8) begin
        if (a == 2 && d == 8'h83) mState = 0;
        else if (a == 0) mRd[mMisc[0]] = d;
        else if (a == 1) mWr[mMisc[0]] = d;
        else if (a == 3) mCtrl = d;
        else if (a == 5) mStrap = d;
        else if (a == 6) mMisc = d;
      end
    end else if (kind != K_IDLE) begin
      mProbe = (kind == K_WR8 && a == 5 && d == 8'hFF);
      if (kind == K_RD16 && a == 1) mState = (mState == 0) ? 1 : 2;
      else if (kind == K_WR8 && a == 2 && d == 8'h03 && mState == 2) mState = 3;
      else mState = 0;
    end
  endtask

  task automatic step(string tag, int kind, logic [2:0] a, logic [15:0] d);
    bit          locked;
    logic [15:0] expRd;
    busRd8   = (kind == K_RD8);
    busRd16  = (kind == K_RD16);
    busWr8   = (kind == K_WR8);
    busWr16  = (kind == K_WR16);
    busAddr  = a;
    busWdata = d;
    tfRdata  = 16'($urandom);
    #1;
    locked = (mState != 3);
    chk(tag, "tfRd8",  16'(tfRd8),  16'(locked && kind == K_RD8));
    chk(tag, "tfRd16", 16'(tfRd16), 16'(locked && kind == K_RD16));
    chk(tag, "tfWr8",  16'(tfWr8),  16'(locked && kind == K_WR8));
    chk(tag, "tfWr16", 16'(tfWr16), 16'(locked && kind == K_WR16));
    if (locked) begin
      chk(tag, "tfAddr", 16'(tfAddr), 16'(a));
      chk(tag, "tfWdata", tfWdata, d);
    end
    if (!locked) expRd = '0;
    else if (kind == K_RD16 && a == 5 && mProbe) expRd = {15'b0, clkSpeed};
    else expRd = tfRdata;
    chk(tag, "busRdata", busRdata, expRd);
    @(posedge clk);
    modelUpdate(kind, a, d[7:0]);
    @(negedge clk);
    checkRegs(tag);
  endtask

  task automatic doReset(logic [7:0] s);
    rstN = 1'b0;
    strapPins = s;
    busRd8 = 0; busRd16 = 0; busWr8 = 0; busWr16 = 0;
    repeat (3) @(posedge clk);
    mState = 0; mProbe = 0; mCtrl = 8'h00; mMisc = 8'h00; mStrap = s;
    for (int i = 0; i < 2; i++) begin mRd[i] = 8'h6B; mWr[i] = 8'h6B; end
    @(negedge clk);
    rstN = 1'b1;
    checkRegs("R1");
    strapPins = ~s;
  endtask

  task automatic unlock(string tag);
    step(tag, K_RD16, 3'd1, 16'h0000);
    step(tag, K_RD16, 3'd1, 16'h0000);
    step(tag, K_WR8, 3'd2, 16'h0003);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    doReset(8'h5A);

    // R2 / R10: locked traffic forwarded, hidden state untouched
    step("R2", K_RD8, 3'd0, 16'h0000);
    step("R10", K_WR8, 3'd0, 16'h0012);
    step("R10", K_WR8, 3'd3, 16'h0085);
    step("R2", K_WR16, 3'd3, 16'hBEEF);
    step("R2", K_RD16, 3'd7, 16'h0000);

    // R4: broken patterns
    step("R4", K_RD16, 3'd1, 16'h0000);
    step("R4", K_RD8, 3'd3, 16'h0000);
    step("R4", K_WR8, 3'd2, 16'h0003);
    step("R4", K_RD16, 3'd1, 16'h0000);
    step("R4", K_RD16, 3'd1, 16'h0000);
    step("R4", K_WR8, 3'd2, 16'h0004);
    step("R4", K_RD16, 3'd1, 16'h0000);
    step("R4", K_RD8, 3'd1, 16'h0000);
    step("R4", K_RD16, 3'd1, 16'h0000);
    step("R4", K_WR8, 3'd2, 16'h0003);
    // idle cycles keep progress, third read keeps "two seen"
    step("R4", K_RD16, 3'd1, 16'h0000);
    step("R4", K_IDLE, 3'd0, 16'h0000);
    step("R4", K_RD16, 3'd1, 16'h0000);
    step("R4", K_RD16, 3'd1, 16'h0000);
    step("R3", K_WR8, 3'd2, 16'h0003);

    // R5 / R6 / R8 while open
    step("R5", K_WR8, 3'd0, 16'h0058);
    step("R5", K_WR8, 3'd1, 16'h0044);
    step("R6", K_WR8, 3'd6, 16'h0001);
    step("R5", K_WR8, 3'd0, 16'h0032);
    step("R5", K_WR8, 3'd1, 16'h0022);
    step("R6", K_WR8, 3'd6, 16'h0020);
    step("R8", K_WR8, 3'd3, 16'h0085);
    step("R6", K_WR8, 3'd5, 16'h000F);
    step("R7", K_RD16, 3'd1, 16'h0000);
    step("R7", K_WR16, 3'd0, 16'h1234);
    step("R7", K_WR8, 3'd2, 16'h0055);
    step("R7", K_WR8, 3'd2, 16'h0083);
    step("R7", K_WR8, 3'd0, 16'h0011);
    step("R8", K_IDLE, 3'd0, 16'h0000);

    // R9 probe
    clkSpeed = 1'b1;
    step("R9", K_WR8, 3'd5, 16'h00FF);
    step("R9", K_RD16, 3'd5, 16'h0000);
    step("R9", K_RD16, 3'd5, 16'h0000);
    step("R9", K_WR8, 3'd5, 16'h00FF);
    step("R9", K_RD8, 3'd0, 16'h0000);
    step("R9", K_RD16, 3'd5, 16'h0000);
    clkSpeed = 1'b0;
    step("R9", K_WR8, 3'd5, 16'h00FF);
    step("R9", K_IDLE, 3'd0, 16'h0000);
    step("R9", K_RD16, 3'd5, 16'h0000);
    // probe arm in the middle of an unlock pattern breaks it
    clkSpeed = 1'b1;
    step("R4", K_RD16, 3'd1, 16'h0000);
    step("R4", K_RD16, 3'd1, 16'h0000);
    step("R9", K_WR8, 3'd5, 16'h00FF);
    step("R9", K_RD16, 3'd5, 16'h0000);
    step("R4", K_WR8, 3'd2, 16'h0003);

    // open, program, override off then on
    unlock("R3");
    step("R8", K_WR8, 3'd3, 16'h0000);
    step("R5", K_WR8, 3'd1, 16'h0077);
    step("R8", K_WR8, 3'd3, 16'h0001);
    step("R7", K_WR8, 3'd2, 16'h0083);

    // R1: second reset with different strap
    doReset(8'hC3);

    // randomized traffic biased to key values
    for (int i = 0; i < 600; i++) begin
      int k;
      logic [2:0] a;
      logic [15:0] d;
      if (i % 40 == 0) unlock("R3");
      k = $urandom_range(0, 4);
      a = 3'($urandom_range(0, 7));
      case ($urandom_range(0, 5))
        0: d = 16'h0003;
        1: d = 16'h0083;
        2: d = 16'h00FF;
        default: d = 16'($urandom);
      endcase
      clkSpeed = 1'($urandom_range(0, 1));
      step("RND", k, a, d);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule